// File: doc/BRIEF.md
# Wide Sample Store Target Adapter

This block presents a 4096-word, 96-bit single-port sample store behind one request/response target socket. A client drives a command, a word address and write data. The block accepts the command in the cycle it is presented, as long as a previous read response is not being held back by the client. Reads return a full 96-bit word together with a data-valid response. Writes complete silently.

Internally the store is a grid of twelve 1024 x 32 single-port banks, four rows deep and three columns wide. The upper address bits pick one bank row. The lower bits pick the word inside every bank of that row. The three column banks of the selected row together hold the 96-bit word. Clients only see the socket, never the bank layout. The store is single-ported, so at most one read or write reaches the banks per clock.

Top module: `wide_store_target`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the response field is 0 (none) and the accept output is 1.
- R2: A read returns the 96-bit word most recently written to the same address.
- R3: A read accepted in cycle N drives the response field to 1 (data valid) with the read data in cycle N+1. When the client takes the response in that cycle, the field returns to 0 in cycle N+2 unless another read was accepted in cycle N+1.
- R4: An accepted write (command 1) raises no response: the response field is 0 in the following cycle.
- R5: Address bits [11:10] select the bank row and bits [9:0] the word within each bank. Writes that differ only in bits [11:10] land in separate storage and do not disturb each other.
- R6: A write updates all three 32-bit slices ([31:0], [63:32], [95:64]) of the addressed word, and each slice reads back independently.
- R7: Command 0 and command 3 are idle: neither changes the store nor raises a response.
- R8: While the response field is 1 and the response-ready input is 0, the response and its read data hold unchanged, the accept output is 0, and any presented command is ignored.
- R9: Data written in one cycle is returned by a read to the same address accepted in the very next cycle.
- R10: When a pending response is taken in the same cycle that a new read is presented, the new read is accepted, so reads can stream at one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command: 0 idle, 1 write, 2 read, 3 idle |
| addr_i | input | 12 | Word address |
| wdata_i | input | 96 | Write data |
| resp_ready_i | input | 1 | Client takes the current response this cycle |
| accept_o | output | 1 | Presented command is accepted this cycle |
| resp_o | output | 2 | Response: 0 none, 1 data valid |
| rdata_o | output | 96 | Read data, valid while resp_o is 1 |

## Verification
Two functions can land in the same cycle. The first is draining a pending read response. The second is accepting the next command, which may be a read whose data must replace the old word in the very next cycle. The bench provokes this with back-to-back reads and with a long random mix of commands under a randomly toggling response-ready. It compares accept, response and data every clock against a behavioural model. A write followed at once by a read of the same address covers store-then-load in adjacent cycles. Commands presented during a stall are judged by later read-back showing they had no effect.

// File: rtl/wst_pkg.sv
package wst_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_WR   = 2'd1,
      CMD_RD   = 2'd2,
      CMD_RSVD = 2'd3
   } cmd_e;

   typedef enum logic [1:0] {
      RSP_NONE = 2'd0,
      RSP_DVA  = 2'd1
   } rsp_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wst_sp_bank.sv
module wst_sp_bank #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   // single port: one access per clock, read output holds when idle
   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            mem[addr] <= wdata;
         end else begin
            rdata <= mem[addr];
         end
      end
   end

endmodule

// File: rtl/wst_cmd_decode.sv
module wst_cmd_decode
   import wst_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int BANK_AW = 10,
   localparam int ROW_W  = ADDR_W - BANK_AW
) (
   input  logic [1:0]         cmd_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               accept_i,
   output logic               bank_en_o,
   output logic               bank_we_o,
   output logic               rd_fire_o,
   output logic [ROW_W-1:0]   row_o,
   output logic [BANK_AW-1:0] word_o
);

   logic is_wr;
   logic is_rd;

   always_comb begin
      is_wr = (cmd_i == CMD_WR);
      is_rd = (cmd_i == CMD_RD);
      bank_en_o = accept_i && (is_wr || is_rd);
      bank_we_o = is_wr;
      rd_fire_o = accept_i && is_rd;
      row_o     = addr_i[ADDR_W-1:BANK_AW];
      word_o    = addr_i[BANK_AW-1:0];
   end

endmodule

// File: rtl/wst_bank_grid.sv
module wst_bank_grid
   import wst_pkg::*;
#(
   parameter int DATA_W     = 96,
   parameter int BANK_W     = 32,
   parameter int ROWS       = 4,
   parameter int BANK_DEPTH = 1024,
   parameter bit ANDOR_MUX  = 1'b0,
   localparam int COLS      = DATA_W / BANK_W,
   localparam int ROW_W     = $clog2(ROWS),
   localparam int BANK_AW   = $clog2(BANK_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               we_i,
   input  logic [ROW_W-1:0]   row_i,
   input  logic [BANK_AW-1:0] word_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o
);

   logic [ROWS-1:0]   row_hit;
   logic [ROWS-1:0]   bank_row_en;
   logic [BANK_W-1:0] bank_q [ROWS][COLS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_hit[r]     = (row_i == ROW_W'(r));
      assign bank_row_en[r] = en_i && row_hit[r];
      for (genvar c = 0; c < COLS; c++) begin : g_col
         wst_sp_bank #(
            .WIDTH (BANK_W),
            .DEPTH (BANK_DEPTH)
         ) u_bank (
            .clk   (clk),
            .en    (bank_row_en[r]),
            .we    (we_i),
            .addr  (word_i),
            .wdata (wdata_i[c*BANK_W +: BANK_W]),
            .rdata (bank_q[r][c])
         );
      end
   end

   // output selection variant
   if (ANDOR_MUX) begin : g_andor
      logic [ROWS-1:0] rd_hit;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_hit <= '0;
            rd_hit[0] <= 1'b1;
         end else if (en_i && !we_i) begin
            rd_hit <= row_hit;
         end
      end
      always_comb begin
         rdata_o = '0;
         for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
               rdata_o[c*BANK_W +: BANK_W] = rdata_o[c*BANK_W +: BANK_W]
                  | (bank_q[r][c] & {BANK_W{rd_hit[r]}});
            end
         end
      end
      AST_RD_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot(rd_hit)); // R5
   end else begin : g_index
      logic [ROW_W-1:0] rd_row;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_row <= '0;
         end else if (en_i && !we_i) begin
            rd_row <= row_i;
         end
      end
      always_comb begin
         for (int c = 0; c < COLS; c++) begin
            rdata_o[c*BANK_W +: BANK_W] = bank_q[rd_row][c];
         end
      end
   end

   AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_row_en)); // R5
   AST_ROW_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> ($countones(bank_row_en) == 1)); // R5

endmodule

// File: rtl/wst_rsp_stage.sv
module wst_rsp_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_fire_i,
   input  logic ready_i,
   output logic vld_o,
   output logic accept_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
      end else if (rd_fire_i) begin
         vld_o <= 1'b1;
      end else if (ready_i) begin
         vld_o <= 1'b0;
      end
   end

   // a stalled response blocks the next command
   assign accept_o = !(vld_o && !ready_i);

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !ready_i) |=> vld_o); // R8
   AST_DVA_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && ready_i && !rd_fire_i) |=> !vld_o); // R3

endmodule

// File: rtl/wide_store_target.sv
module wide_store_target
   import wst_pkg::*;
#(
   parameter int DATA_W     = 96,
   parameter int DEPTH      = 4096,
   parameter int BANK_W     = 32,
   parameter int BANK_DEPTH = 1024,
   parameter bit ANDOR_MUX  = 1'b0,
   localparam int ADDR_W    = $clog2(DEPTH),
   localparam int BANK_AW   = $clog2(BANK_DEPTH),
   localparam int ROWS      = DEPTH / BANK_DEPTH,
   localparam int ROW_W     = ADDR_W - BANK_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              resp_ready_i,
   output logic              accept_o,
   output logic [1:0]        resp_o,
   output logic [DATA_W-1:0] rdata_o
);

   // elaboration-time parameter checks
   if (DATA_W % BANK_W != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of BANK_W");
   end
   if (!is_pow2(DEPTH) || !is_pow2(BANK_DEPTH)) begin : g_bad_depth
      $error("DEPTH and BANK_DEPTH must be powers of two");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("DEPTH must span at least two bank rows");
   end

   logic               bank_en;
   logic               bank_we;
   logic               rd_fire;
   logic [ROW_W-1:0]   row_sel;
   logic [BANK_AW-1:0] word_sel;
   logic               rsp_vld;

   wst_cmd_decode #(
      .ADDR_W  (ADDR_W),
      .BANK_AW (BANK_AW)
   ) u_decode (
      .cmd_i     (cmd_i),
      .addr_i    (addr_i),
      .accept_i  (accept_o),
      .bank_en_o (bank_en),
      .bank_we_o (bank_we),
      .rd_fire_o (rd_fire),
      .row_o     (row_sel),
      .word_o    (word_sel)
   );

   wst_bank_grid #(
      .DATA_W     (DATA_W),
      .BANK_W     (BANK_W),
      .ROWS       (ROWS),
      .BANK_DEPTH (BANK_DEPTH),
      .ANDOR_MUX  (ANDOR_MUX)
   ) u_grid (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (bank_en),
      .we_i    (bank_we),
      .row_i   (row_sel),
      .word_i  (word_sel),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o)
   );

   wst_rsp_stage u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_fire_i (rd_fire),
      .ready_i   (resp_ready_i),
      .vld_o     (rsp_vld),
      .accept_o  (accept_o)
   );

   assign resp_o = rsp_vld ? RSP_DVA : RSP_NONE;

   AST_RD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && cmd_i == CMD_RD) |=> (resp_o == RSP_DVA)); // R3
   AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && cmd_i == CMD_WR) |=> (resp_o == RSP_NONE)); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && (cmd_i == CMD_IDLE || cmd_i == CMD_RSVD)) |=> (resp_o == RSP_NONE)); // R7
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_o == RSP_DVA && !resp_ready_i) |=> (resp_o == RSP_DVA && $stable(rdata_o))); // R8

endmodule

// File: tb/tb_wide_store_target.sv
module tb_wide_store_target;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  cmd_i;
   logic [11:0] addr_i;
   logic [95:0] wdata_i;
   logic        resp_ready_i;
   logic        accept_o;
   logic [1:0]  resp_o;
   logic [95:0] rdata_o;

   always #10 clk = ~clk;

   wide_store_target dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_i        (cmd_i),
      .addr_i       (addr_i),
      .wdata_i      (wdata_i),
      .resp_ready_i (resp_ready_i),
      .accept_o     (accept_o),
      .resp_o       (resp_o),
      .rdata_o      (rdata_o)
   );

   int          checks = 0;
   int          errors = 0;
   logic [95:0] model [int];
   logic        exp_vld = 1'b0;
   logic [95:0] exp_data = '0;
   logic [11:0] pool [16];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic cyc(input logic [1:0] c, input logic [11:0] a,
                      input logic [95:0] d, input logic rdy, input string tag);
      logic exp_acc;
      cmd_i = c; addr_i = a; wdata_i = d; resp_ready_i = rdy;
      #1;
      exp_acc = !(exp_vld && !rdy);
      chk(accept_o == exp_acc, tag, "accept", 96'(accept_o), 96'(exp_acc));
      @(posedge clk);
      if (exp_acc && c == 2'd2) begin
         exp_vld  = 1'b1;
         exp_data = model.exists(int'(a)) ? model[int'(a)] : '0;
      end else if (rdy) begin
         exp_vld = 1'b0;
      end
      if (exp_acc && c == 2'd1) model[int'(a)] = d;
      @(negedge clk);
      chk(resp_o == {1'b0, exp_vld}, tag, "resp", 96'(resp_o), 96'({1'b0, exp_vld}));
      if (exp_vld) chk(rdata_o == exp_data, tag, "rdata", rdata_o, exp_data);
   endtask

   function automatic logic [95:0] pat(input int s);
      return {32'hA5000000 ^ 32'(s * 7), 32'h3C000000 ^ 32'(s * 13), 32'h0F000000 ^ 32'(s * 29)};
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmd_i = 2'd0; addr_i = '0; wdata_i = '0; resp_ready_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(resp_o == 2'd0, "R1", "resp in reset", 96'(resp_o), 96'd0);
      chk(accept_o == 1'b1, "R1", "accept in reset", 96'(accept_o), 96'd1);
      rst_n = 1'b1;
      cyc(2'd0, 12'h000, '0, 1'b1, "R1");

      // R5: same low bits, each row distinct
      for (int r = 0; r < 4; r++) cyc(2'd1, {2'(r), 10'h155}, pat(r + 1), 1'b1, "R5");
      for (int r = 0; r < 4; r++) cyc(2'd2, {2'(r), 10'h155}, '0, 1'b1, "R5");
      cyc(2'd0, 12'h000, '0, 1'b1, "R3");

      // R6: each slice separately
      cyc(2'd1, 12'h7A0, {32'hFFFFFFFF, 32'h0, 32'h0}, 1'b1, "R6");
      cyc(2'd1, 12'h7A1, {32'h0, 32'hFFFFFFFF, 32'h0}, 1'b1, "R6");
      cyc(2'd1, 12'h7A2, {32'h0, 32'h0, 32'hFFFFFFFF}, 1'b1, "R6");
      cyc(2'd2, 12'h7A0, '0, 1'b1, "R6");
      cyc(2'd2, 12'h7A1, '0, 1'b1, "R6");
      cyc(2'd2, 12'h7A2, '0, 1'b1, "R6");
      cyc(2'd0, 12'h000, '0, 1'b1, "R3");

      // R4 write quiet, R9 read right after write
      cyc(2'd1, 12'hC33, pat(40), 1'b1, "R4");
      cyc(2'd2, 12'hC33, '0, 1'b1, "R9");
      cyc(2'd1, 12'hC33, pat(41), 1'b1, "R9");
      cyc(2'd2, 12'hC33, '0, 1'b1, "R9");
      cyc(2'd0, 12'h000, '0, 1'b1, "R3");

      // R7 idle codes do not write
      cyc(2'd3, 12'hC33, pat(99), 1'b1, "R7");
      cyc(2'd0, 12'hC33, pat(98), 1'b1, "R7");
      cyc(2'd2, 12'hC33, '0, 1'b1, "R7");
      cyc(2'd0, 12'h000, '0, 1'b1, "R7");

      // R8 stall: commands ignored, response held
      cyc(2'd2, 12'h155, '0, 1'b1, "R8");
      cyc(2'd1, 12'h155, pat(77), 1'b0, "R8");
      cyc(2'd2, 12'hC33, '0, 1'b0, "R8");
      cyc(2'd0, 12'h000, '0, 1'b1, "R8");
      cyc(2'd2, 12'h155, '0, 1'b1, "R8");
      cyc(2'd0, 12'h000, '0, 1'b1, "R3");

      // R10 streaming reads
      for (int i = 0; i < 4; i++) cyc(2'd2, {2'(i), 10'h155}, '0, 1'b1, "R10");
      cyc(2'd0, 12'h000, '0, 1'b1, "R10");

      // R2 random mix over a written pool with random ready
      for (int i = 0; i < 16; i++) begin
         pool[i] = 12'((i * 389 + 17) % 4096);
         cyc(2'd1, pool[i], pat(200 + i), 1'b1, "R2");
      end
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] c;
         c = 2'($urandom_range(0, 3));
         cyc(c, pool[$urandom_range(0, 15)], {$urandom, $urandom, $urandom},
             ($urandom_range(0, 3) != 0), "R2");
      end
      cyc(2'd0, 12'h000, '0, 1'b1, "R2");

      summary();
      $finish;
   end

endmodule